// File: doc/BRIEF.md
# Sequential Arrow Sign Lamp Sequencer

This block drives the five lamps of a sequential arrow-style road sign. A clocked Moore machine holds one of four phases in two flip-flops and decodes the lamp vector from the phase alone. The pattern builds up cumulatively. First the sign is dark. Then the first pair of lamps lights, then the first four, then all five. The sign then goes dark again and repeats.

An internal prescaler divides the system clock. It issues a single-cycle step strobe once every `TICK_DIV` clocks, and the phase moves only on that strobe. A plain on/off switch input gates the sequence. While the switch is on, each strobe advances the phase. While it is off, the next strobe returns the sign to dark, and the sign stays dark. The switch and the lamps are plain control pins with no handshake. There is no data stream, so the block has no valid/ready interface and nothing can apply back-pressure.

Top module: `arrow_sign_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) makes `lamps` read 5'b00000 from the next cycle on and restarts the prescaler count.
- R2: `step_tick` is high for exactly one cycle in every `TICK_DIV` cycles. After reset is released, its first high cycle is the `TICK_DIV`-th cycle.
- R3: `lamps` (lamp 1 at bit 0) only ever shows one of 5'b00000, 5'b00011, 5'b01111 or 5'b11111.
- R4: With the switch on in a step cycle, the pattern advances dark -> 5'b00011 -> 5'b01111 -> 5'b11111 -> dark in the cycle after that step.
- R5: `lamps` keeps its value in the cycle after any cycle where `step_tick` is low.
- R6: With the switch off in a step cycle, `lamps` is 5'b00000 in the next cycle, whatever the phase was, and stays dark while the switch remains off.
- R7: Turning the switch on from the dark idle state gives 5'b00011 in the cycle after the first step cycle in which the switch is on. The sign is dark until then.
- R8: The switch is sampled only in step cycles. Toggling it between steps has no effect on `lamps`.
- R9: Reset wins over a step strobe in the same cycle. The sign goes dark and the next strobe comes `TICK_DIV` cycles after reset is released.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sign_on | input | 1 | On/off switch for the sequence |
| step_tick | output | 1 | One-cycle strobe at which the phase may change |
| lamps | output | 5 | Lamp drive, bit 0 is lamp 1, 1 = lit |

## Verification
Two functions can fall in the same cycle. The first pair is switch release and phase advance: the switch drops exactly in a step cycle while the sign shows four lamps. The bench provokes this by lowering `sign_on` in the strobe cycle. It judges the result as correct only if the sign is dark afterwards and never shows five lamps. The second pair is reset and the step strobe: the bench raises reset in a strobe cycle. It judges that the sign goes dark, and that the next strobe is counted from reset release and not from the old prescaler phase.

// File: rtl/arrow_sign_pkg.sv
package arrow_sign_pkg;

  localparam int LAMP_COUNT = 5;

  typedef enum logic [1:0] {
    PH_DARK = 2'd0,
    PH_PAIR = 2'd1,
    PH_QUAD = 2'd2,
    PH_FULL = 2'd3
  } sign_phase_e;

  // Phase from which a given lamp (0-based) is lit; the pattern is cumulative.
  function automatic sign_phase_e lamp_first_phase(input int idx);
    if (idx < 2)      return PH_PAIR;
    else if (idx < 4) return PH_QUAD;
    else              return PH_FULL;
  endfunction

endpackage

// File: rtl/step_prescaler.sv
module step_prescaler #(
  parameter int TICK_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sign_phase_fsm.sv
module sign_phase_fsm
  import arrow_sign_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        sign_on,
  output sign_phase_e phase
);
  sign_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (tick) begin
      if (!sign_on) begin
        phase_d = PH_DARK;
      end else begin
        unique case (phase_q)
          PH_DARK: phase_d = PH_PAIR;
          PH_PAIR: phase_d = PH_QUAD;
          PH_QUAD: phase_d = PH_FULL;
          PH_FULL: phase_d = PH_DARK;
          default: phase_d = PH_DARK;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_DARK;
    else     phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
  import arrow_sign_pkg::*;
(
  input  sign_phase_e           phase,
  output logic [LAMP_COUNT-1:0] lamps
);
  for (genvar i = 0; i < LAMP_COUNT; i++) begin : g_lamp
    localparam logic [1:0] FIRST = lamp_first_phase(i);
    assign lamps[i] = (phase >= FIRST);
  end
endmodule

// File: rtl/arrow_sign_seq.sv
module arrow_sign_seq
  import arrow_sign_pkg::*;
#(
  parameter int TICK_DIV = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sign_on,
  output logic       step_tick,
  output logic [4:0] lamps
);
  sign_phase_e phase;

  step_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .tick (step_tick)
  );

  sign_phase_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .tick    (step_tick),
    .sign_on (sign_on),
    .phase   (phase)
  );

  lamp_decode u_dec (
    .phase (phase),
    .lamps (lamps)
  );
endmodule

// File: rtl/arrow_sign_chk.sv
module arrow_sign_chk #(
  parameter int TICK_DIV = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       sign_on,
  input logic       step_tick,
  input logic [4:0] lamps
);
  int unsigned gap_q;

  always_ff @(posedge clk) begin
    if (rst || step_tick) gap_q <= 0;
    else                  gap_q <= gap_q + 1;
  end

  assert_reset_dark_R1: assert property (@(posedge clk)
    rst |=> lamps == 5'b00000);

  assert_tick_on_time_R2: assert property (@(posedge clk) disable iff (rst)
    step_tick |-> gap_q == TICK_DIV - 1);

  assert_tick_not_late_R2: assert property (@(posedge clk) disable iff (rst)
    gap_q == TICK_DIV - 1 |-> step_tick);

  assert_legal_pattern_R3: assert property (@(posedge clk) disable iff (rst)
    lamps == 5'b00000 || lamps == 5'b00011 || lamps == 5'b01111 || lamps == 5'b11111);

  assert_pair_to_quad_R4: assert property (@(posedge clk) disable iff (rst)
    step_tick && sign_on && lamps == 5'b00011 |=> lamps == 5'b01111);

  assert_full_wraps_R4: assert property (@(posedge clk) disable iff (rst)
    step_tick && sign_on && lamps == 5'b11111 |=> lamps == 5'b00000);

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (rst)
    !step_tick |=> $stable(lamps));

  assert_off_goes_dark_R6: assert property (@(posedge clk) disable iff (rst)
    step_tick && !sign_on |=> lamps == 5'b00000);
endmodule

bind arrow_sign_seq arrow_sign_chk #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sign_on   (sign_on),
  .step_tick (step_tick),
  .lamps     (lamps)
);

// File: tb/test_arrow_sign_seq.sv
`timescale 1ns/100ps
module test_arrow_sign_seq;
  localparam int DIV = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sign_on = 1'b0;
  logic       step_tick;
  logic [4:0] lamps;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model
  int  m_cnt = 0;
  int  m_ph = 0;
  bit  m_prev_rst = 1;
  bit  m_prev_tick = 0;
  bit  m_prev_on = 0;

  always #2.5 clk = ~clk;

  arrow_sign_seq #(.TICK_DIV(DIV)) i_arrow_sign_seq (
    .clk       (clk),
    .rst       (rst),
    .sign_on   (sign_on),
    .step_tick (step_tick),
    .lamps     (lamps)
  );

  function automatic logic [4:0] pattern_of(input int ph);
    case (ph)
      1:       return 5'b00011;
      2:       return 5'b01111;
      3:       return 5'b11111;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic bit legal(input logic [4:0] v);
    return v == 5'b00000 || v == 5'b00011 || v == 5'b01111 || v == 5'b11111;
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive inputs (at a falling edge), advance model, compare at next falling edge.
  task automatic cyc(input logic r, input logic o);
    string tag;
    bit tick_now;
    rst = r;
    sign_on = o;
    tick_now = (m_cnt == DIV - 1);
    m_prev_rst = r;
    m_prev_tick = tick_now;
    m_prev_on = o;
    if (r) begin
      m_cnt = 0;
      m_ph = 0;
    end else begin
      m_cnt = tick_now ? 0 : m_cnt + 1;
      if (tick_now) m_ph = o ? (m_ph + 1) % 4 : 0;
    end
    @(negedge clk);
    if (m_prev_rst)                    tag = "R1";
    else if (!m_prev_tick)             tag = "R5";
    else if (!m_prev_on)               tag = "R6";
    else                               tag = "R4";
    check(tag, lamps, pattern_of(m_ph));
    check("R2", {4'b0, step_tick}, {4'b0, (m_cnt == DIV - 1) ? 1'b1 : 1'b0});
    check("R3", {4'b0, legal(lamps)}, 5'b00001);
  endtask

  task automatic run_to_tick(input logic o);
    while (m_cnt != DIV - 1) cyc(1'b0, o);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    // R1: reset state
    repeat (3) cyc(1'b1, 1'b0);
    check("R1", lamps, 5'b00000);

    // R4/R2/R5: run sequence for three full rounds
    repeat (DIV * 12) cyc(1'b0, 1'b1);

    // R6: switch drops in the step cycle while four lamps are lit
    while (!(m_ph == 2 && m_cnt == DIV - 1)) cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    check("R6", lamps, 5'b00000);
    repeat (DIV * 3) cyc(1'b0, 1'b0);
    check("R6", lamps, 5'b00000);

    // R7: switch on between steps; dark until the step, then the first pair
    cyc(1'b0, 1'b1);
    while (m_cnt != DIV - 1) begin
      cyc(1'b0, 1'b1);
      check("R7", lamps, 5'b00000);
    end
    cyc(1'b0, 1'b1);
    check("R7", lamps, 5'b00011);

    // R8: switch toggles off between steps but is on at each step
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 1'b1);
      while (m_cnt != DIV - 1) cyc(1'b0, 1'b0);
      cyc(1'b0, 1'b1);
    end
    check("R8", lamps, 5'b00000);
    cyc(1'b0, 1'b0);
    while (m_cnt != DIV - 1) cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b1);
    check("R8", lamps, 5'b00011);

    // R9: reset asserted exactly in a step cycle
    run_to_tick(1'b1);
    cyc(1'b1, 1'b1);
    check("R9", lamps, 5'b00000);
    for (int k = 0; k < DIV - 1; k++) begin
      cyc(1'b0, 1'b1);
      check("R9", {4'b0, step_tick}, {4'b0, (k == DIV - 2) ? 1'b1 : 1'b0});
    end
    cyc(1'b0, 1'b1);
    check("R9", lamps, 5'b00011);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic r, o;
      r = ($urandom % 100) < 1;
      o = ($urandom % 100) < 85;
      cyc(r, o);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule